// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

The controller gathers 64 level-sensitive request lines and presents to the processor one interrupt level and one vector number. Each request line copies its level into a pending bit on every clock. A source can win only if its pending (or forced) bit is set, it is enabled and it is not masked. Each source has an 8-bit priority byte. A nonzero priority byte enables the source, and a zero byte disables it. Among the qualifying sources, the one with the largest priority byte wins. When two sources have equal priority bytes, the higher source index wins.

Software uses a 32-bit register bus with an 8-bit byte offset. It can read the pending and force registers. It can read and write the 64-bit mask in two halves. It writes the priority bytes and reads them back. Two byte-wide command offsets set or clear a single mask bit, or the whole mask. A software acknowledge offset returns the vector currently presented to the processor.

The winner is found by combinational logic from the register state. The result is captured into the level and vector output registers, so the outputs follow any register change after one clock edge.

Top module: `prio_intc`

## Requirements
- R1: A source qualifies only when (pending OR forced) AND enabled AND NOT masked holds for its bit. Mask bit n, pending bit n and enable bit n all belong to source n.
- R2: The winner is the qualifying source with the largest priority byte. On equal priority bytes, the higher source index wins.
- R3: The vector output is 64 plus the winner's index. With no qualifying source, the vector is 24 and the level is 0.
- R4: The level output equals the winner's priority byte.
- R5: Byte offset 0x40+n (n = 0..63) reads and writes the priority byte of source n in data bits [7:0]. Writing 0 disables source n, and writing any nonzero value enables it.
- R6: Pending bit n follows request input n, one clock edge late. It reads at 0x00 (bits 63:32) and at 0x04 (bits 31:0). Writes to these offsets have no effect.
- R7: The mask reads and writes at 0x08 (bits 63:32) and at 0x0C (bits 31:0), where a 1 masks the source. The force register reads at 0x10 and 0x14, is zero and ignores writes.
- R8: A write to 0x1C with data bit 6 set sets the whole mask. Otherwise it sets the mask bit numbered by data bits [5:0].
- R9: A write to 0x1D with data bit 6 set clears the whole mask. Otherwise it clears the mask bit numbered by data bits [5:0].
- R10: A read of 0xE0 returns the current vector in bits [7:0]. A read of any unlisted offset returns 0.
- R11: After reset the mask is all ones. Pending, force, enables and priority bytes are zero, the vector is 24 and the level is 0.
- R12: After a register write, the outputs change on the next clock edge. After a request input changes, the outputs change on the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 64 | Level-sensitive request lines, bit n for source n |
| busWe | input | 1 | Write strobe for one cycle |
| busRe | input | 1 | Read strobe |
| busAddr | input | 8 | Byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the offset |
| irqLevel | output | 8 | Priority of the winning source, 0 when idle |
| irqVector | output | 8 | Vector number of the winner, 24 when idle |

## Verification
Two events can reach the selector in the same cycle: a request line can change while a register write changes the mask or a priority byte. The bench provokes this in a random phase. In each step it changes the request lines and issues priority, mask and command writes back to back. It then waits until both paths have settled, computes the expected level and vector from its own model of the rules, and queues them. A monitor compares the queued items against the outputs. Directed cases check equal-priority ties, the exact cycle in which the outputs change, and the bulk mask commands.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int NUM_SRC = 64;
  localparam int IDX_W   = $clog2(NUM_SRC);
  localparam int HALF_W  = NUM_SRC / 2;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] OFS_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h1D;
  localparam logic [ADDR_W-1:0] OFS_SW_ACK   = 8'hE0;
  localparam logic [1:0]        PRIO_PAGE    = 2'b01;

  typedef enum logic [3:0] {
    RD_ZERO, RD_PEND_HI, RD_PEND_LO, RD_MASK_HI, RD_MASK_LO,
    RD_FORCE_HI, RD_FORCE_LO, RD_PRIO, RD_VECTOR
  } rdSel_e;

  typedef struct packed {
    logic             maskHiWr;
    logic             maskLoWr;
    logic             maskSetCmd;
    logic             maskClrCmd;
    logic             prioWr;
    logic [IDX_W-1:0] srcIdx;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
(
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe
);
  logic inPrioPage;
  assign inPrioPage = (busAddr[ADDR_W-1:IDX_W] == PRIO_PAGE);

  always_comb begin
    strobe            = '0;
    strobe.rdSel      = RD_ZERO;
    strobe.srcIdx     = busAddr[IDX_W-1:0];
    strobe.prioWr     = busWe && inPrioPage;
    strobe.maskHiWr   = busWe && (busAddr == OFS_MASK_HI);
    strobe.maskLoWr   = busWe && (busAddr == OFS_MASK_LO);
    strobe.maskSetCmd = busWe && (busAddr == OFS_MASK_SET);
    strobe.maskClrCmd = busWe && (busAddr == OFS_MASK_CLR);
    if (busRe) begin
      if (inPrioPage) strobe.rdSel = RD_PRIO;
      else begin
        case (busAddr)
          OFS_PEND_HI:  strobe.rdSel = RD_PEND_HI;
          OFS_PEND_LO:  strobe.rdSel = RD_PEND_LO;
          OFS_MASK_HI:  strobe.rdSel = RD_MASK_HI;
          OFS_MASK_LO:  strobe.rdSel = RD_MASK_LO;
          OFS_FORCE_HI: strobe.rdSel = RD_FORCE_HI;
          OFS_FORCE_LO: strobe.rdSel = RD_FORCE_LO;
          OFS_SW_ACK:   strobe.rdSel = RD_VECTOR;
          default:      strobe.rdSel = RD_ZERO;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_intc_datapath.sv
module prio_intc_datapath
  import prio_intc_pkg::*;
#(
  parameter int PRIO_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_IDLE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  strobe_t            strobe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [PRIO_W-1:0]  irqLevel,
  output logic [VEC_W-1:0]   irqVector
);
  localparam int CMD_ALL_BIT = IDX_W;

  logic [NUM_SRC-1:0] pendReg, maskReg, forceReg, enReg, candVec;
  logic [PRIO_W-1:0]  prioMem [NUM_SRC];
  logic [PRIO_W-1:0]  bestLvl;
  logic [IDX_W-1:0]   bestIdx;
  logic               found;
  logic [VEC_W-1:0]   nextVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReg  <= '0;
      forceReg <= '0;
    end else begin
      pendReg  <= reqIn;
      forceReg <= forceReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) maskReg <= '1;
    else if (strobe.maskHiWr) maskReg[NUM_SRC-1:HALF_W] <= busWdata[HALF_W-1:0];
    else if (strobe.maskLoWr) maskReg[HALF_W-1:0] <= busWdata[HALF_W-1:0];
    else if (strobe.maskSetCmd) begin
      if (busWdata[CMD_ALL_BIT]) maskReg <= '1;
      else maskReg[busWdata[IDX_W-1:0]] <= 1'b1;
    end else if (strobe.maskClrCmd) begin
      if (busWdata[CMD_ALL_BIT]) maskReg <= '0;
      else maskReg[busWdata[IDX_W-1:0]] <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rstN) begin
        prioMem[g] <= '0;
        enReg[g]   <= 1'b0;
      end else if (strobe.prioWr && strobe.srcIdx == IDX_W'(g)) begin
        prioMem[g] <= busWdata[PRIO_W-1:0];
        enReg[g]   <= |busWdata[PRIO_W-1:0];
      end
    end
    assign candVec[g] = (pendReg[g] | forceReg[g]) & enReg[g] & ~maskReg[g];
  end

  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    found   = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (candVec[i] && prioMem[i] >= bestLvl) begin
        bestLvl = prioMem[i];
        bestIdx = IDX_W'(i);
        found   = 1'b1;
      end
    end
    nextVec = found ? VEC_W'(VEC_BASE) + VEC_W'(bestIdx) : VEC_W'(VEC_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLevel  <= '0;
      irqVector <= VEC_W'(VEC_IDLE);
    end else begin
      irqLevel  <= found ? bestLvl : '0;
      irqVector <= nextVec;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_PEND_HI:  busRdata = pendReg[NUM_SRC-1:HALF_W];
      RD_PEND_LO:  busRdata = pendReg[HALF_W-1:0];
      RD_MASK_HI:  busRdata = maskReg[NUM_SRC-1:HALF_W];
      RD_MASK_LO:  busRdata = maskReg[HALF_W-1:0];
      RD_FORCE_HI: busRdata = forceReg[NUM_SRC-1:HALF_W];
      RD_FORCE_LO: busRdata = forceReg[HALF_W-1:0];
      RD_PRIO:     busRdata = DATA_W'(prioMem[strobe.srcIdx]);
      RD_VECTOR:   busRdata = DATA_W'(irqVector);
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int PRIO_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_IDLE = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [PRIO_W-1:0]  irqLevel,
  output logic [VEC_W-1:0]   irqVector
);
  strobe_t strobe;

  prio_intc_ctrl u_ctrl (
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .strobe(strobe)
  );

  prio_intc_datapath #(
    .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .strobe(strobe),
    .busWdata(busWdata), .busRdata(busRdata),
    .irqLevel(irqLevel), .irqVector(irqVector)
  );
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk
  import prio_intc_pkg::*;
#(
  parameter int PRIO_W   = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int VEC_IDLE = 24
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWe,
  input logic               busRe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic [DATA_W-1:0]  busRdata,
  input logic [PRIO_W-1:0]  irqLevel,
  input logic [VEC_W-1:0]   irqVector
);
  // R3
  idle_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == '0) == (irqVector == VEC_W'(VEC_IDLE)));

  // R3
  vector_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqVector == VEC_W'(VEC_IDLE)) ||
    (irqVector >= VEC_W'(VEC_BASE) && irqVector < VEC_W'(VEC_BASE + NUM_SRC)));

  // R10
  sw_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == OFS_SW_ACK) |-> busRdata == DATA_W'(irqVector));

  // R10
  unlisted_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr >= 8'h18 && busAddr < 8'h40) |-> busRdata == '0);

  // R8
  mask_all_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFS_MASK_SET && busWdata[IDX_W]) |=> ##1
    irqVector == VEC_W'(VEC_IDLE));
endmodule

bind prio_intc prio_intc_chk #(
  .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_IDLE(VEC_IDLE)
) u_chk (
  .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .irqLevel(irqLevel),
  .irqVector(irqVector)
);

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [63:0] reqIn = '0;
  logic        busWe = 0, busRe = 0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  irqLevel, irqVector;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0]  mPrio [64];
  logic [63:0] mMask;

  typedef struct { int req; logic [7:0] lvl; logic [7:0] vec; } exp_t;
  exp_t expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u_prio_intc (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqLevel(irqLevel), .irqVector(irqVector)
  );

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 0;
    if (a[7:6] == 2'b01) mPrio[a[5:0]] = d[7:0];
    else if (a == 8'h08) mMask[63:32] = d;
    else if (a == 8'h0C) mMask[31:0] = d;
    else if (a == 8'h1C) begin if (d[6]) mMask = '1; else mMask[d[5:0]] = 1'b1; end
    else if (a == 8'h1D) begin if (d[6]) mMask = '0; else mMask[d[5:0]] = 1'b0; end
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRe = 1; busAddr = a;
    #1 d = busRdata;
    busRe = 0;
  endtask

  // model of R1 R2 R3 R4
  task automatic model(output logic [7:0] lvl, output logic [7:0] vec);
    bit f = 0;
    lvl = 0; vec = 8'd24;
    for (int i = 0; i < 64; i++)
      if (reqIn[i] && mPrio[i] != 0 && !mMask[i] && mPrio[i] >= lvl) begin
        lvl = mPrio[i]; vec = 8'(64 + i); f = 1;
      end
    if (!f) lvl = 0;
  endtask

  task automatic expectOut(input int req);
    exp_t e;
    repeat (3) @(negedge clk);
    e.req = req;
    model(e.lvl, e.vec);
    expQ.push_back(e);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      chk(e.req, {24'b0, irqLevel}, {24'b0, e.lvl});
      chk(e.req, {24'b0, irqVector}, {24'b0, e.vec});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    for (int i = 0; i < 64; i++) mPrio[i] = 0;
    mMask = '1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    chk(11, {24'b0, irqLevel}, 0);
    chk(11, {24'b0, irqVector}, 24);
    busRead(8'h08, rd); chk(11, rd, 32'hFFFF_FFFF);
    busRead(8'h0C, rd); chk(11, rd, 32'hFFFF_FFFF);
    busRead(8'h45, rd); chk(11, rd, 0);

    // R6 pending follows inputs, writes ignored
    reqIn = 64'h8000_0001_0000_0003;
    @(negedge clk); @(negedge clk);
    busRead(8'h00, rd); chk(6, rd, 32'h8000_0001);
    busRead(8'h04, rd); chk(6, rd, 32'h0000_0003);
    busWrite(8'h04, 32'h0);
    busRead(8'h04, rd); chk(6, rd, 32'h0000_0003);

    // R7 mask halves, force read-only
    busWrite(8'h0C, 32'h1234_5678);
    busRead(8'h0C, rd); chk(7, rd, 32'h1234_5678);
    busWrite(8'h10, 32'hFFFF_FFFF);
    busRead(8'h10, rd); chk(7, rd, 0);
    busRead(8'h14, rd); chk(7, rd, 0);

    // R9 clear all, R8 set single and all
    busWrite(8'h1D, 32'h40);
    busRead(8'h08, rd); chk(9, rd, 0);
    busRead(8'h0C, rd); chk(9, rd, 0);
    busWrite(8'h1C, 32'd37);
    busRead(8'h08, rd); chk(8, rd, 32'h0000_0020);
    busWrite(8'h1C, 32'h40);
    busRead(8'h0C, rd); chk(8, rd, 32'hFFFF_FFFF);
    busWrite(8'h1D, 32'd37);
    busRead(8'h08, rd); chk(9, rd, 32'hFFFF_FFDF);

    // R5 priority byte access
    busWrite(8'h45, 32'h0000_0003);
    busRead(8'h45, rd); chk(5, rd, 3);

    // R2 tie: sources 3 and 10 at priority 4, higher index wins
    busWrite(8'h1D, 32'h40);
    busWrite(8'h45, 32'h0);
    reqIn = '0; reqIn[3] = 1; reqIn[10] = 1;
    busWrite(8'h43, 32'd4);
    busWrite(8'h4A, 32'd4);
    expectOut(2);
    chk(2, {24'b0, irqVector}, 74);
    // R4 higher priority at lower index wins, level follows byte
    reqIn[2] = 1;
    busWrite(8'h42, 32'd6);
    expectOut(4);
    // R1 masked source drops out
    busWrite(8'h1C, 32'd2);
    expectOut(1);
    // R5 zero byte disables source 10
    busWrite(8'h4A, 32'd0);
    expectOut(5);
    chk(5, {24'b0, irqVector}, 67);
    // R10 software acknowledge and unlisted offset
    busRead(8'hE0, rd); chk(10, rd, 67);
    busRead(8'h30, rd); chk(10, rd, 0);
    // R3 no qualifying source
    reqIn = '0;
    expectOut(3);

    // R12 exact timing after request change
    busWrite(8'h54, 32'd7);
    repeat (3) @(negedge clk);
    reqIn[20] = 1;
    @(negedge clk);
    chk(12, {24'b0, irqVector}, 24);
    @(negedge clk);
    chk(12, {24'b0, irqVector}, 84);
    // R12 exact timing after register write
    @(negedge clk);
    busWe = 1; busAddr = 8'h1C; busWdata = 32'd20;
    @(negedge clk);
    busWe = 0;
    chk(12, {24'b0, irqVector}, 84);
    @(negedge clk);
    chk(12, {24'b0, irqVector}, 24);
    mMask[20] = 1;

    // random: request changes mixed with register writes (R1 R2 R3 R4)
    busWrite(8'h1D, 32'h40);
    for (int it = 0; it < 60; it++) begin
      reqIn = {$urandom, $urandom} & {$urandom, $urandom};
      for (int k = 0; k < 3; k++)
        busWrite(8'(8'h40 + $urandom_range(0, 63)), 32'($urandom_range(0, 3)));
      case ($urandom_range(0, 3))
        0: busWrite(8'h0C, $urandom & $urandom);
        1: busWrite(8'h1C, 32'($urandom_range(0, 63)));
        2: busWrite(8'h1D, 32'($urandom_range(0, 63)));
        default: busWrite(8'h08, $urandom & $urandom & $urandom);
      endcase
      expectOut(it % 2 == 0 ? 2 : 4);
    end

    wait (expQ.size() == 0);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule